// File: doc/BRIEF.md
# Six-Channel Multi-Mode PWM Generator

The block drives six pulse-width-modulated outputs from one shared phase counter. A clock divider sets how often the counter advances. A resolution field sets how many counter bits make up one PWM cycle. Each channel compares the shared phase, shifted by its own phase offset, against its current duty value. It then drives its output high or low and applies an optional inversion last.

A channel runs in one of three modes. In steady mode it holds one duty value. In blink mode it alternates between two duty values for programmable numbers of cycles. In heartbeat mode it sweeps its duty value back and forth between two limits in programmable steps. At each limit it clamps and reverses, so the sweep never wraps around the 16-bit range.

All settings are written through a simple synchronous write port. A channel's duty, offset and mode settings are copied into a working copy only at the start of a PWM cycle, so a pulse in progress is never cut short. The enable and invert masks act on the next clock.

Top module: `pwm_gen`

## Requirements
- R1: After reset all outputs are 0, the counter is stopped and every setting reads as zero.
- R2: With the counter running, one PWM cycle lasts (D+1)*2^(S+1) clocks, where D is the 27-bit divider and S the 4-bit resolution. D = 0 advances the phase on every clock.
- R3: While the run bit is 0, the phase and divider are held at 0. An enabled steady channel with duty A > 0 then drives a constant 1, and one with duty 0 drives a constant 0.
- R4: In steady mode the output is high while (phase - offset) mod 2^16 < A. Per PWM cycle this gives ceil(A / 2^(15-S)) phase steps high, capped at 2^(S+1).
- R5: A channel whose enable bit is 0 drives its invert bit. An enabled channel drives its compare result XOR its invert bit.
- R6: A phase offset P that is a multiple of 2^(15-S) delays the channel's rising edge by (P / 2^(15-S))*(D+1) clocks relative to a channel with offset 0.
- R7: In blink mode the channel uses duty A for X+1 PWM cycles, then duty B for Y+1 cycles, and repeats.
- R8: In heartbeat mode (blink and heartbeat bits both 1) the duty starts at A and moves toward B by Y+1 once every X+1 cycles. A step that would pass max(A,B) or min(A,B), including one that would pass 0xFFFF or 0, is clamped to that limit and reverses the direction. The duty never wraps.
- R9: With the heartbeat bit set and the blink bit clear, the channel behaves as a steady channel.
- R10: Writes to offset, duty, blink or mode settings take effect only at the next PWM cycle start. Every pulse has the width of either the old setting or the new one.
- R11: The write map is as follows. Address 0 holds divider [26:0], resolution [30:27] and run [31]. Address 1 holds the enable mask [5:0] and the invert mask [21:16], with bit i for channel i. Channel c uses address 8+4c for offset [15:0], blink bit [16] and heartbeat bit [17]; address 9+4c for duty A [15:0] and duty B [31:16]; and address 10+4c for X [15:0] and Y [31:16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the setting port |
| cfg_addr | input | 5 | Word address of the write |
| cfg_wdata | input | 32 | Write data |
| pwm_out | output | 6 | Channel outputs, bit i for channel i |

## Verification
A setting write and a PWM cycle start can land in the same clock. The bench provokes this by rewriting a running channel's duty at an arbitrary clock inside a cycle. It then judges every following pulse, which must have either the old width or the new width, never a cut or stretched one. Heartbeat reversal and the period counter also meet at each cycle start. Sweeps chosen to overflow past 0xFFFF and to underflow below zero are judged by pulse widths that must alternate between the two clamped limits.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CH_COUNT  = 6;
    localparam int DIV_W     = 27;
    localparam int RES_W     = 4;
    localparam int VAL_W     = 16;
    localparam int DATA_W    = 32;
    localparam int CH_BASE   = 8;
    localparam int CH_STRIDE = 4;
    localparam int INV_LSB   = 16;
    localparam int RUN_BIT   = DATA_W - 1;
    localparam int BLINK_BIT = VAL_W;
    localparam int HEART_BIT = VAL_W + 1;
    localparam logic [RES_W-1:0] RES_TOP = RES_W'(VAL_W - 1);

    typedef struct packed {
        logic              run;
        logic [RES_W-1:0]  res;
        logic [DIV_W-1:0]  div;
    } glob_cfg_t;

    typedef struct packed {
        logic              blink_en;
        logic              heart_en;
        logic [VAL_W-1:0]  offset;
        logic [VAL_W-1:0]  duty_a;
        logic [VAL_W-1:0]  duty_b;
        logic [VAL_W-1:0]  hold_x;
        logic [VAL_W-1:0]  step_y;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        MODE_STEADY = 2'd0,
        MODE_BLINK  = 2'd1,
        MODE_HEART  = 2'd2
    } mode_e;

    function automatic mode_e mode_of(input logic blink_en, input logic heart_en);
        if (!blink_en)     return MODE_STEADY;
        else if (heart_en) return MODE_HEART;
        else               return MODE_BLINK;
    endfunction

    function automatic logic [VAL_W:0] phase_step(input logic [RES_W-1:0] res);
        return (VAL_W+1)'(1) << (RES_TOP - res);
    endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT,
    parameter int ADDR_W = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output glob_cfg_t                   gcfg,
    output logic [NUM_CH-1:0]           en_mask,
    output logic [NUM_CH-1:0]           inv_mask,
    output chan_cfg_t [NUM_CH-1:0]      ccfg
);

    localparam logic [DATA_W-1:0] MASK_USED =
        (DATA_W'((64'd1 << NUM_CH) - 1)) | (DATA_W'((64'd1 << NUM_CH) - 1) << INV_LSB);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[DATA_W-1:HEART_BIT+1], wdata & ~MASK_USED};

    always_ff @(posedge clk) begin
        if (rst) begin
            gcfg     <= '0;
            en_mask  <= '0;
            inv_mask <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(0)) begin
                gcfg.div <= wdata[DIV_W-1:0];
                gcfg.res <= wdata[DIV_W +: RES_W];
                gcfg.run <= wdata[RUN_BIT];
            end
            if (addr == ADDR_W'(1)) begin
                en_mask  <= wdata[NUM_CH-1:0];
                inv_mask <= wdata[INV_LSB +: NUM_CH];
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        localparam int BASE = CH_BASE + CH_STRIDE * c;
        chan_cfg_t r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (we) begin
                if (addr == ADDR_W'(BASE)) begin
                    r.offset   <= wdata[VAL_W-1:0];
                    r.blink_en <= wdata[BLINK_BIT];
                    r.heart_en <= wdata[HEART_BIT];
                end
                if (addr == ADDR_W'(BASE + 1)) begin
                    r.duty_a <= wdata[VAL_W-1:0];
                    r.duty_b <= wdata[DATA_W-1:VAL_W];
                end
                if (addr == ADDR_W'(BASE + 2)) begin
                    r.hold_x <= wdata[VAL_W-1:0];
                    r.step_y <= wdata[DATA_W-1:VAL_W];
                end
            end
        end
        assign ccfg[c] = r;
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  glob_cfg_t         gcfg,
    output logic [VAL_W-1:0]  phase,
    output logic              cyc_start
);

    logic [DIV_W-1:0] div_cnt;
    logic [VAL_W:0]   step;
    logic [VAL_W:0]   sum;
    logic             tick;

    assign tick      = gcfg.run && (div_cnt >= gcfg.div);
    assign step      = phase_step(gcfg.res);
    assign sum       = {1'b0, phase} + step;
    assign cyc_start = tick && sum[VAL_W];

    always_ff @(posedge clk) begin
        if (rst || !gcfg.run) begin
            div_cnt <= '0;
            phase   <= '0;
        end else begin
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
            if (tick) phase <= sum[VAL_W-1:0];
        end
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        cyc_start |=> (phase == '0)); // R2

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !gcfg.run |=> (phase == '0)); // R3

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_cfg_t         cfg_in,
    input  logic              run,
    input  logic              cyc_start,
    input  logic [VAL_W-1:0]  phase,
    input  logic              en,
    input  logic              inv,
    output logic              out
);

    chan_cfg_t         sh;
    mode_e             md, md_next;
    logic              load, reinit;
    logic [VAL_W-1:0]  lo, hi, cyc_cnt, cyc_lim, hb_duty, duty_now, rel;
    logic              use_b, hb_up;
    logic [VAL_W:0]    stride, up_sum, dn_diff;

    assign load    = cyc_start || !run;
    assign md      = mode_of(sh.blink_en, sh.heart_en);
    assign md_next = mode_of(cfg_in.blink_en, cfg_in.heart_en);
    assign reinit  = !run || (md == MODE_STEADY) ||
                     (load && ((md_next != md) ||
                               (cfg_in.duty_a != sh.duty_a) ||
                               (cfg_in.duty_b != sh.duty_b)));

    assign lo      = (sh.duty_a < sh.duty_b) ? sh.duty_a : sh.duty_b;
    assign hi      = (sh.duty_a < sh.duty_b) ? sh.duty_b : sh.duty_a;
    assign stride  = {1'b0, sh.step_y} + (VAL_W+1)'(1);
    assign up_sum  = {1'b0, hb_duty} + stride;
    assign dn_diff = {1'b0, hb_duty} - stride;
    assign cyc_lim = (md == MODE_BLINK && use_b) ? sh.step_y : sh.hold_x;

    // working copy, refreshed only at a cycle boundary or while stopped
    always_ff @(posedge clk) begin
        if (rst)       sh <= '0;
        else if (load) sh <= cfg_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_cnt <= '0;
            use_b   <= 1'b0;
            hb_duty <= '0;
            hb_up   <= 1'b1;
        end else if (reinit) begin
            cyc_cnt <= '0;
            use_b   <= 1'b0;
            hb_duty <= cfg_in.duty_a;
            hb_up   <= (cfg_in.duty_b >= cfg_in.duty_a);
        end else if (cyc_start) begin
            if (cyc_cnt >= cyc_lim) begin
                cyc_cnt <= '0;
                if (md == MODE_BLINK) begin
                    use_b <= ~use_b;
                end else if (hb_up) begin
                    if (up_sum >= {1'b0, hi}) begin
                        hb_duty <= hi;
                        hb_up   <= 1'b0;
                    end else begin
                        hb_duty <= up_sum[VAL_W-1:0];
                    end
                end else begin
                    if (dn_diff[VAL_W] || (dn_diff[VAL_W-1:0] <= lo)) begin
                        hb_duty <= lo;
                        hb_up   <= 1'b1;
                    end else begin
                        hb_duty <= dn_diff[VAL_W-1:0];
                    end
                end
            end else begin
                cyc_cnt <= cyc_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        case (md)
            MODE_BLINK: duty_now = use_b ? sh.duty_b : sh.duty_a;
            MODE_HEART: duty_now = hb_duty;
            default:    duty_now = sh.duty_a;
        endcase
    end

    assign rel = phase - sh.offset;

    always_ff @(posedge clk) begin
        if (rst) out <= 1'b0;
        else     out <= (en && (rel < duty_now)) ^ inv;
    end

    AST_HB_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (md == MODE_HEART) |-> (hb_duty >= lo && hb_duty <= hi)); // R8

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !cyc_start) |=> (sh == $past(sh))); // R10

    AST_OFF_DRIVES_INV: assert property (@(posedge clk) disable iff (rst)
        !en |=> (out == $past(inv))); // R5

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
    import pwm_pkg::*;
#(
    parameter  int NUM_CH = CH_COUNT,
    localparam int ADDR_W = $clog2(CH_BASE + CH_STRIDE * NUM_CH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [NUM_CH-1:0]  pwm_out
);

    glob_cfg_t                gcfg;
    logic [NUM_CH-1:0]        en_mask;
    logic [NUM_CH-1:0]        inv_mask;
    chan_cfg_t [NUM_CH-1:0]   ccfg;
    logic [VAL_W-1:0]         phase;
    logic                     cyc_start;

    pwm_cfg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .gcfg     (gcfg),
        .en_mask  (en_mask),
        .inv_mask (inv_mask),
        .ccfg     (ccfg)
    );

    pwm_timebase u_tb (
        .clk       (clk),
        .rst       (rst),
        .gcfg      (gcfg),
        .phase     (phase),
        .cyc_start (cyc_start)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .cfg_in    (ccfg[c]),
            .run       (gcfg.run),
            .cyc_start (cyc_start),
            .phase     (phase),
            .en        (en_mask[c]),
            .inv       (inv_mask[c]),
            .out       (pwm_out[c])
        );
    end

endmodule

// File: tb/tb_pwm_gen.sv
module tb_pwm_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [5:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pwm_gen dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pwm_out   (pwm_out)
    );

    typedef struct packed {
        logic [26:0] div;
        logic [3:0]  res;
        logic [15:0] duty;
        logic        inv;
        logic [8:0]  hi;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{27'd0, 4'd3, 16'h3000, 1'b0, 9'd3},
        '{27'd2, 4'd3, 16'h3000, 1'b0, 9'd3},
        '{27'd0, 4'd3, 16'h0000, 1'b0, 9'd0},
        '{27'd0, 4'd3, 16'hFFFF, 1'b0, 9'd16},
        '{27'd0, 4'd3, 16'h3000, 1'b1, 9'd3},
        '{27'd0, 4'd0, 16'h8000, 1'b0, 9'd1},
        '{27'd1, 4'd7, 16'h1234, 1'b0, 9'd19},
        '{27'd0, 4'd3, 16'h0001, 1'b0, 9'd1},
        '{27'd4, 4'd1, 16'h4001, 1'b0, 9'd2}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[4:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic glob(input bit run, input int res, input int div);
        wr(0, {run, res[3:0], div[26:0]});
    endtask

    task automatic masks(input logic [5:0] en, input logic [5:0] inv);
        wr(1, {10'b0, inv, 10'b0, en});
    endtask

    task automatic chan(input int c, input logic [15:0] ofs, input bit blink, input bit heart,
                        input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] x, input logic [15:0] y);
        wr(8 + 4*c, {14'b0, heart, blink, ofs});
        wr(9 + 4*c, {b, a});
        wr(10 + 4*c, {y, x});
    endtask

    task automatic count_high(input int ch, input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) h++;
        end
    endtask

    task automatic wait_rise(input int ch, output int n);
        logic prev;
        prev = pwm_out[ch];
        n = -1;
        for (int i = 1; i <= 3000; i++) begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) begin
                n = i;
                return;
            end
            prev = pwm_out[ch];
        end
    endtask

    task automatic next_pulse(input int ch, output int w);
        int n;
        wait_rise(ch, n);
        w = 0;
        if (n < 0) return;
        w = 1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) w++;
            else return;
        end
    endtask

    task automatic stop_all();
        glob(0, 0, 0);
        masks(6'h00, 6'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int h, per, expv, n, w, prev_w, sum, sixes, mx, mn;
        bit ok;
        int ws [8];

        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs low after reset
        chk(pwm_out == 6'h00, "R1 reset outputs", int'(pwm_out), 0);
        count_high(0, 20, h);
        chk(h == 0, "R1 idle after reset", h, 0);

        // table walk: R2 period, R4 steady compare, R5 inversion
        for (int i = 0; i < NV; i++) begin
            stop_all();
            masks(6'h01, {5'b0, VECS[i].inv});
            chan(0, 16'h0000, 1'b0, 1'b0, VECS[i].duty, 16'h0, 16'h0, 16'h0);
            glob(1, int'(VECS[i].res), int'(VECS[i].div));
            per = (int'(VECS[i].div) + 1) << (int'(VECS[i].res) + 1);
            repeat (2 * per) @(negedge clk);
            count_high(0, 4 * per, h);
            expv = VECS[i].inv ? ((1 << (int'(VECS[i].res) + 1)) - int'(VECS[i].hi))
                               : int'(VECS[i].hi);
            expv = 4 * (int'(VECS[i].div) + 1) * expv;
            chk(h == expv, $sformatf("R4 vector %0d", i), h, expv);
        end

        // R2: rise-to-rise period with divider 2, resolution 1 -> 12 clocks
        stop_all();
        masks(6'h01, 6'h00);
        chan(0, 16'h0, 1'b0, 1'b0, 16'h4000, 16'h0, 16'h0, 16'h0);
        glob(1, 1, 2);
        wait_rise(0, n);
        wait_rise(0, n);
        chk(n == 12, "R2 period", n, 12);

        // R3: stopped counter holds phase at zero
        stop_all();
        masks(6'h03, 6'h00);
        chan(0, 16'h0, 1'b0, 1'b0, 16'h3000, 16'h0, 16'h0, 16'h0);
        chan(1, 16'h0, 1'b0, 1'b0, 16'h0000, 16'h0, 16'h0, 16'h0);
        repeat (3) @(negedge clk);
        count_high(0, 20, h);
        chk(h == 20, "R3 stopped duty>0 high", h, 20);
        count_high(1, 20, h);
        chk(h == 0, "R3 stopped duty=0 low", h, 0);

        // R5: disabled channel drives its invert bit
        masks(6'h00, 6'h04);
        glob(1, 3, 0);
        chan(2, 16'h0, 1'b0, 1'b0, 16'h3000, 16'h0, 16'h0, 16'h0);
        repeat (3) @(negedge clk);
        count_high(2, 32, h);
        chk(h == 32, "R5 disabled inverted", h, 32);

        // R6: offset 0x4000 at resolution 3 delays the rise by 4 clocks
        stop_all();
        masks(6'h03, 6'h00);
        chan(0, 16'h0000, 1'b0, 1'b0, 16'h3000, 16'h0, 16'h0, 16'h0);
        chan(1, 16'h4000, 1'b0, 1'b0, 16'h3000, 16'h0, 16'h0, 16'h0);
        glob(1, 3, 0);
        repeat (20) @(negedge clk);
        wait_rise(0, n);
        wait_rise(1, n);
        chk(n == 4, "R6 offset delay", n, 4);

        // R7: blink widths 2,2,6 repeating (A=0x2000 x2, B=0x6000 x1)
        stop_all();
        masks(6'h01, 6'h00);
        chan(0, 16'h0, 1'b1, 1'b0, 16'h2000, 16'h6000, 16'd1, 16'd0);
        glob(1, 3, 0);
        next_pulse(0, w);
        sum = 0; sixes = 0;
        for (int k = 0; k < 9; k++) begin
            next_pulse(0, w);
            sum += w;
            if (w == 6) sixes++;
        end
        chk(sum == 30, "R7 blink width sum", sum, 30);
        chk(sixes == 3, "R7 blink B count", sixes, 3);

        // R8: sweep 2..6..2 in steps of one phase step
        stop_all();
        masks(6'h01, 6'h00);
        chan(0, 16'h0, 1'b1, 1'b1, 16'h2000, 16'h6000, 16'd0, 16'h0FFF);
        glob(1, 3, 0);
        next_pulse(0, prev_w);
        ok = 1; mx = prev_w; mn = prev_w;
        for (int k = 0; k < 16; k++) begin
            next_pulse(0, w);
            if (w - prev_w != 1 && prev_w - w != 1) ok = 0;
            if (w > mx) mx = w;
            if (w < mn) mn = w;
            prev_w = w;
        end
        chk(ok, "R8 sweep unit steps", w, prev_w);
        chk(mx == 6, "R8 sweep upper limit", mx, 6);
        chk(mn == 2, "R8 sweep lower limit", mn, 2);

        // R8: underflow below zero clamps to min (A=0x3000 down to B=0x1000, step 0x8000)
        stop_all();
        masks(6'h01, 6'h00);
        chan(0, 16'h0, 1'b1, 1'b1, 16'h3000, 16'h1000, 16'd0, 16'h7FFF);
        glob(1, 3, 0);
        next_pulse(0, prev_w);
        ok = 1;
        for (int k = 0; k < 8; k++) begin
            next_pulse(0, w);
            if (!((w == 1 || w == 3) && w != prev_w)) ok = 0;
            prev_w = w;
        end
        chk(ok, "R8 underflow clamp", w, 1);

        // R8: overflow past 0xFFFF clamps to max (A=0xD000, B=0xE000, step 0x8000)
        stop_all();
        masks(6'h01, 6'h00);
        chan(0, 16'h0, 1'b1, 1'b1, 16'hD000, 16'hE000, 16'd0, 16'h7FFF);
        glob(1, 3, 0);
        next_pulse(0, prev_w);
        ok = 1;
        for (int k = 0; k < 8; k++) begin
            next_pulse(0, w);
            if (!((w == 13 || w == 14) && w != prev_w)) ok = 0;
            prev_w = w;
        end
        chk(ok, "R8 overflow clamp", w, 14);

        // R9: heartbeat bit without blink stays steady at A
        stop_all();
        masks(6'h01, 6'h00);
        chan(0, 16'h0, 1'b0, 1'b1, 16'h2000, 16'h6000, 16'd0, 16'h0FFF);
        glob(1, 3, 0);
        ok = 1;
        for (int k = 0; k < 6; k++) begin
            next_pulse(0, w);
            if (w != 2) ok = 0;
        end
        chk(ok, "R9 heartbeat without blink", w, 2);

        // R10: duty rewritten mid-cycle; every pulse is 3 or 8 wide, ending at 8
        stop_all();
        masks(6'h01, 6'h00);
        chan(0, 16'h0, 1'b0, 1'b0, 16'h3000, 16'h0, 16'h0, 16'h0);
        glob(1, 3, 0);
        fork
            begin
                repeat (37) @(negedge clk);
                wr(9, {16'h0000, 16'h8000});
            end
            begin
                for (int k = 0; k < 8; k++) next_pulse(0, ws[k]);
            end
        join
        ok = 1;
        for (int k = 0; k < 8; k++) if (ws[k] != 3 && ws[k] != 8) ok = 0;
        chk(ok, "R10 no cut pulses", ws[0], 3);
        chk(ws[7] == 8, "R10 new duty applied", ws[7], 8);

        // R11: last channel reached through addresses 28..30
        stop_all();
        masks(6'h20, 6'h00);
        wr(28, 32'h0000_0000);
        wr(29, 32'h0000_5000);
        wr(30, 32'h0000_0000);
        glob(1, 3, 0);
        repeat (32) @(negedge clk);
        count_high(5, 64, h);
        chk(h == 20, "R11 channel 5 map", h, 20);
        count_high(4, 16, h);
        chk(h == 0, "R11 channel 4 untouched", h, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule